// File: doc/BRIEF.md
# Snooping Write-Invalidate Line Coherence Controller

This block tracks the coherence state of one cache line in one of two caches that share a snooping bus. The caches keep coherence by invalidation: before a cache may write a line, every other copy is removed. The controller takes single-cycle event strobes. Some come from the local cache: read hit, write hit, and a read miss tagged with what the other cache was seen to hold. Others come from the bus: a snoop hit from another cache's read or write, and completion of a fill, invalidate or write-back. From these it produces the encoded line state and level requests for a bus read, an invalidate broadcast or a write-back.

A parameter picks the protocol family: three stable states (Invalid, Shared, Modified), four (adds Exclusive), or five (adds Owned, a dirty shared state that supplies data without first writing memory back). Transient states sit between the stable ones. One state waits for a fill. One waits until all other copies are invalidated. One waits for a write-back. While it is in a transient state, the controller responds only to that state's completion strobe.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset the state code is 000 (Invalid) and no request output is high.
- R2: In Invalid, `miss_copy_shared` or `miss_copy_owned` enters the fill state with `req_bus_rd` high, and `bus_done` then lands in Shared (001). `miss_no_copy` fills to Exclusive (010) when PROTO is 1 or 2, and to Shared when PROTO is 0.
- R3: In Exclusive, a read snoop leads to Shared, a write snoop leads to Invalid, and a local write hit goes directly to Modified without raising `req_inval`.
- R4: A write hit in Shared, Owned or Invalid enters the invalidate-wait state with `req_inval` high. `bus_done` then lands in Modified.
- R5: In Modified, a write snoop enters the write-back state with `req_wb` high, and `wb_done` then lands in Invalid.
- R6: In Modified, a read snoop moves to Owned (100) with no write-back when PROTO is 2. With PROTO 0 or 1 it writes back and then lands in Shared.
- R7: In Owned, a read snoop keeps Owned with no request, and a write snoop writes back and then lands in Invalid.
- R8: In a transient state, every strobe other than that state's completion strobe is ignored: `bus_done` ends fill and invalidate-wait, and `wb_done` ends write-back.
- R9: When a stable state sees several strobes in one cycle, the first present in the order write snoop, read snoop, write hit, read miss with a copy, read miss with no copy, read hit is the only one acted on.
- R10: State codes. PROTO 0: I 000, S 001, M 010, fill 011, inval-wait 100, write-back 101. PROTO 1: I 000, S 001, E 010, M 011, fill 100, inval-wait 101, write-back 110. PROTO 2: I 000, S 001, E 010, M 011, O 100, fill 101, write-back 110, inval-wait 111.
- R11: In Shared, a read snoop or a local read hit keeps Shared, and a write snoop leads to Invalid.
- R12: `req_bus_rd` is high only in fill, `req_inval` only in invalidate-wait and `req_wb` only in write-back, so at most one request is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_hit | input | 1 | Local read hit strobe |
| wr_hit | input | 1 | Local write hit strobe |
| snp_rd_hit | input | 1 | Another cache read this line |
| snp_wr_hit | input | 1 | Another cache writes this line |
| miss_copy_shared | input | 1 | Read miss, other cache holds a shared copy |
| miss_copy_owned | input | 1 | Read miss, other cache holds an owned copy |
| miss_no_copy | input | 1 | Read miss, no other copy exists |
| bus_done | input | 1 | Fill or invalidate completed |
| wb_done | input | 1 | Write-back completed |
| state_code | output | 3 | Encoded line state |
| req_bus_rd | output | 1 | Bus read request |
| req_inval | output | 1 | Invalidate broadcast request |
| req_wb | output | 1 | Write-back request |

## Verification
The assertions check on every cycle that the request outputs are mutually exclusive, that fill and write-back hold steady until their completion strobe, and that invalidate-wait ends in Modified. They also check that a write snoop on Modified always raises a write-back, that a write hit in Exclusive moves to Modified without an invalidate, and that Owned appears only in the five-state family. Three instances, one per protocol family, receive the same strobes. The bench compares each instance against its own model on directed walks and on a long pseudo-random event sequence. Only these scenarios show the per-family targets of a miss or a read snoop, the priority among simultaneous strobes, and that each code value is correct.

// File: rtl/coh_pkg.sv
package coh_pkg;

  localparam int unsigned STATE_W = 3;

  typedef enum logic [2:0] {
    ST_I, ST_S, ST_E, ST_M, ST_O, ST_FILL, ST_WAIT, ST_WB
  } line_st_e;

  typedef enum logic [2:0] {
    EV_NONE, EV_SNP_WR, EV_SNP_RD, EV_WR_HIT, EV_MISS_COPY, EV_MISS_ALONE, EV_RD_HIT
  } line_ev_e;

  // three stable states
  function automatic logic [STATE_W-1:0] enc_three(line_st_e s);
    case (s)
      ST_S:    return 3'b001;
      ST_M:    return 3'b010;
      ST_FILL: return 3'b011;
      ST_WAIT: return 3'b100;
      ST_WB:   return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  // four stable states
  function automatic logic [STATE_W-1:0] enc_four(line_st_e s);
    case (s)
      ST_S:    return 3'b001;
      ST_E:    return 3'b010;
      ST_M:    return 3'b011;
      ST_FILL: return 3'b100;
      ST_WAIT: return 3'b101;
      ST_WB:   return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  // five stable states
  function automatic logic [STATE_W-1:0] enc_five(line_st_e s);
    case (s)
      ST_S:    return 3'b001;
      ST_E:    return 3'b010;
      ST_M:    return 3'b011;
      ST_O:    return 3'b100;
      ST_FILL: return 3'b101;
      ST_WB:   return 3'b110;
      ST_WAIT: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [STATE_W-1:0] enc_any(int unsigned proto, line_st_e s);
    if (proto == 0) return enc_three(s);
    if (proto == 1) return enc_four(s);
    return enc_five(s);
  endfunction

endpackage

// File: rtl/coh_event_pri.sv
module coh_event_pri
  import coh_pkg::*;
(
  input  logic     rd_hit,
  input  logic     wr_hit,
  input  logic     snp_rd_hit,
  input  logic     snp_wr_hit,
  input  logic     miss_copy,
  input  logic     miss_alone,
  output line_ev_e ev_sel
);
  // snoops beat local events; a miss that saw any copy beats one that saw none
  always_comb begin
    if (snp_wr_hit)      ev_sel = EV_SNP_WR;
    else if (snp_rd_hit) ev_sel = EV_SNP_RD;
    else if (wr_hit)     ev_sel = EV_WR_HIT;
    else if (miss_copy)  ev_sel = EV_MISS_COPY;
    else if (miss_alone) ev_sel = EV_MISS_ALONE;
    else if (rd_hit)     ev_sel = EV_RD_HIT;
    else                 ev_sel = EV_NONE;
  end
endmodule

// File: rtl/coh_next_state.sv
module coh_next_state
  import coh_pkg::*;
#(
  parameter int unsigned PROTO = 2
) (
  input  line_st_e cur_st,
  input  line_st_e tgt_st,
  input  line_ev_e ev_sel,
  input  logic     bus_done,
  input  logic     wb_done,
  output line_st_e nxt_st,
  output line_st_e nxt_tgt
);
  localparam bit HAS_E = (PROTO >= 1);
  localparam bit HAS_O = (PROTO >= 2);

  always_comb begin
    nxt_st  = cur_st;
    nxt_tgt = tgt_st;
    case (cur_st)
      ST_FILL: if (bus_done) nxt_st = tgt_st;
      ST_WAIT: if (bus_done) nxt_st = ST_M;
      ST_WB:   if (wb_done)  nxt_st = tgt_st;
      ST_I: begin
        if (ev_sel == EV_WR_HIT) nxt_st = ST_WAIT;
        else if (ev_sel == EV_MISS_COPY) begin
          nxt_st  = ST_FILL;
          nxt_tgt = ST_S;
        end else if (ev_sel == EV_MISS_ALONE) begin
          nxt_st  = ST_FILL;
          nxt_tgt = HAS_E ? ST_E : ST_S;
        end
      end
      ST_S: begin
        if (ev_sel == EV_SNP_WR)      nxt_st = ST_I;
        else if (ev_sel == EV_WR_HIT) nxt_st = ST_WAIT;
      end
      ST_E: begin
        if (ev_sel == EV_SNP_WR)      nxt_st = ST_I;
        else if (ev_sel == EV_SNP_RD) nxt_st = ST_S;
        else if (ev_sel == EV_WR_HIT) nxt_st = ST_M;
      end
      ST_M: begin
        if (ev_sel == EV_SNP_WR) begin
          nxt_st  = ST_WB;
          nxt_tgt = ST_I;
        end else if (ev_sel == EV_SNP_RD) begin
          if (HAS_O) nxt_st = ST_O;
          else begin
            nxt_st  = ST_WB;
            nxt_tgt = ST_S;
          end
        end
      end
      ST_O: begin
        if (ev_sel == EV_SNP_WR) begin
          nxt_st  = ST_WB;
          nxt_tgt = ST_I;
        end else if (ev_sel == EV_WR_HIT) nxt_st = ST_WAIT;
      end
      default: nxt_st = ST_I;
    endcase
  end
endmodule

// File: rtl/coh_state_enc.sv
module coh_state_enc
  import coh_pkg::*;
#(
  parameter int unsigned PROTO = 2
) (
  input  line_st_e             cur_st,
  output logic [STATE_W-1:0]   state_code,
  output logic                 req_bus_rd,
  output logic                 req_inval,
  output logic                 req_wb
);
  generate
    if (PROTO == 0) begin : g_three
      assign state_code = enc_three(cur_st);
    end else if (PROTO == 1) begin : g_four
      assign state_code = enc_four(cur_st);
    end else begin : g_five
      assign state_code = enc_five(cur_st);
    end
  endgenerate

  assign req_bus_rd = (cur_st == ST_FILL);
  assign req_inval  = (cur_st == ST_WAIT);
  assign req_wb     = (cur_st == ST_WB);
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int unsigned PROTO = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_hit,
  input  logic         wr_hit,
  input  logic         snp_rd_hit,
  input  logic         snp_wr_hit,
  input  logic         miss_copy_shared,
  input  logic         miss_copy_owned,
  input  logic         miss_no_copy,
  input  logic         bus_done,
  input  logic         wb_done,
  output logic [2:0]   state_code,
  output logic         req_bus_rd,
  output logic         req_inval,
  output logic         req_wb
);
  line_st_e cur_st, tgt_st, nxt_st, nxt_tgt;
  line_ev_e ev_sel;

  coh_event_pri u_pri (
    .rd_hit     (rd_hit),
    .wr_hit     (wr_hit),
    .snp_rd_hit (snp_rd_hit),
    .snp_wr_hit (snp_wr_hit),
    .miss_copy  (miss_copy_shared | miss_copy_owned),
    .miss_alone (miss_no_copy),
    .ev_sel     (ev_sel)
  );

  coh_next_state #(.PROTO(PROTO)) u_nxt (
    .cur_st   (cur_st),
    .tgt_st   (tgt_st),
    .ev_sel   (ev_sel),
    .bus_done (bus_done),
    .wb_done  (wb_done),
    .nxt_st   (nxt_st),
    .nxt_tgt  (nxt_tgt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_st <= ST_I;
      tgt_st <= ST_I;
    end else begin
      cur_st <= nxt_st;
      tgt_st <= nxt_tgt;
    end
  end

  coh_state_enc #(.PROTO(PROTO)) u_enc (
    .cur_st     (cur_st),
    .state_code (state_code),
    .req_bus_rd (req_bus_rd),
    .req_inval  (req_inval),
    .req_wb     (req_wb)
  );
endmodule

// File: rtl/coh_line_chk.sv
module coh_line_chk
  import coh_pkg::*;
#(
  parameter int unsigned PROTO = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state_code,
  input logic       req_bus_rd,
  input logic       req_inval,
  input logic       req_wb,
  input logic       wr_hit,
  input logic       snp_rd_hit,
  input logic       snp_wr_hit,
  input logic       bus_done,
  input logic       wb_done,
  input line_st_e   cur_st
);
  localparam logic [2:0] CODE_M = enc_any(PROTO, ST_M);
  localparam logic [2:0] CODE_E = enc_any(PROTO, ST_E);

  p_one_request_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_bus_rd, req_inval, req_wb}));

  p_fill_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_bus_rd && !bus_done |=> req_bus_rd && $stable(state_code));

  p_wb_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_wb && !wb_done |=> req_wb && $stable(state_code));

  p_wait_ends_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_inval && bus_done |=> state_code == CODE_M && !req_inval);

  p_mod_snpwr_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_bus_rd && !req_inval && !req_wb && state_code == CODE_M && snp_wr_hit |=> req_wb);

  p_excl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (PROTO != 0) && !req_bus_rd && !req_inval && !req_wb && state_code == CODE_E
      && wr_hit && !snp_rd_hit && !snp_wr_hit |=> state_code == CODE_M && !req_inval);

  p_owned_five_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (PROTO != 2) |-> cur_st != ST_O);
endmodule

bind coh_line_ctrl coh_line_chk #(.PROTO(PROTO)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state_code (state_code),
  .req_bus_rd (req_bus_rd),
  .req_inval  (req_inval),
  .req_wb     (req_wb),
  .wr_hit     (wr_hit),
  .snp_rd_hit (snp_rd_hit),
  .snp_wr_hit (snp_wr_hit),
  .bus_done   (bus_done),
  .wb_done    (wb_done),
  .cur_st     (cur_st)
);

// File: tb/test_coh_line_ctrl.sv
module test_coh_line_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] ev = '0; // 0 rd,1 wr,2 snp_rd,3 snp_wr,4 miss_sh,5 miss_none,6 miss_own,7 bus_done,8 wb_done
  logic [2:0] code [3];
  logic rq_rd [3], rq_iv [3], rq_wb [3];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int m_st [3], m_tgt [3]; // 0 I,1 S,2 E,3 M,4 O,5 fill,6 wait,7 wb

  always #2 clk = ~clk;

  coh_line_ctrl #(.PROTO(0)) i_coh_line_ctrl_msi (
    .clk(clk), .rst_n(rst_n), .rd_hit(ev[0]), .wr_hit(ev[1]), .snp_rd_hit(ev[2]),
    .snp_wr_hit(ev[3]), .miss_copy_shared(ev[4]), .miss_copy_owned(ev[6]),
    .miss_no_copy(ev[5]), .bus_done(ev[7]), .wb_done(ev[8]),
    .state_code(code[0]), .req_bus_rd(rq_rd[0]), .req_inval(rq_iv[0]), .req_wb(rq_wb[0]));
  coh_line_ctrl #(.PROTO(1)) i_coh_line_ctrl_mesi (
    .clk(clk), .rst_n(rst_n), .rd_hit(ev[0]), .wr_hit(ev[1]), .snp_rd_hit(ev[2]),
    .snp_wr_hit(ev[3]), .miss_copy_shared(ev[4]), .miss_copy_owned(ev[6]),
    .miss_no_copy(ev[5]), .bus_done(ev[7]), .wb_done(ev[8]),
    .state_code(code[1]), .req_bus_rd(rq_rd[1]), .req_inval(rq_iv[1]), .req_wb(rq_wb[1]));
  coh_line_ctrl #(.PROTO(2)) i_coh_line_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_hit(ev[0]), .wr_hit(ev[1]), .snp_rd_hit(ev[2]),
    .snp_wr_hit(ev[3]), .miss_copy_shared(ev[4]), .miss_copy_owned(ev[6]),
    .miss_no_copy(ev[5]), .bus_done(ev[7]), .wb_done(ev[8]),
    .state_code(code[2]), .req_bus_rd(rq_rd[2]), .req_inval(rq_iv[2]), .req_wb(rq_wb[2]));

  // R10 code tables, written per family
  function automatic int exp_code(int fam, int st);
    int t3 [8] = '{0, 1, -1, 2, -1, 3, 4, 5};
    int t4 [8] = '{0, 1, 2, 3, -1, 4, 5, 6};
    int t5 [8] = '{0, 1, 2, 3, 4, 5, 7, 6};
    if (fam == 0) return t3[st];
    if (fam == 1) return t4[st];
    return t5[st];
  endfunction

  function automatic string tag_of(int st);
    case (st)
      0: return "R2"; 1: return "R11"; 2: return "R3"; 3: return "R5";
      4: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // model of requirements R2-R9, R11
  task automatic model_step(int fam, logic [8:0] m);
    int s = m_st[fam];
    if (s == 5) begin if (m[7]) m_st[fam] = m_tgt[fam]; end
    else if (s == 6) begin if (m[7]) m_st[fam] = 3; end
    else if (s == 7) begin if (m[8]) m_st[fam] = m_tgt[fam]; end
    else begin
      int e; // 1 sw,2 sr,3 wh,4 copy,5 alone
      e = m[3] ? 1 : m[2] ? 2 : m[1] ? 3 : (m[4] | m[6]) ? 4 : m[5] ? 5 : 0;
      case (s)
        0: if (e == 3) m_st[fam] = 6;
           else if (e == 4) begin m_st[fam] = 5; m_tgt[fam] = 1; end
           else if (e == 5) begin m_st[fam] = 5; m_tgt[fam] = (fam == 0) ? 1 : 2; end
        1: if (e == 1) m_st[fam] = 0; else if (e == 3) m_st[fam] = 6;
        2: if (e == 1) m_st[fam] = 0; else if (e == 2) m_st[fam] = 1;
           else if (e == 3) m_st[fam] = 3;
        3: if (e == 1) begin m_st[fam] = 7; m_tgt[fam] = 0; end
           else if (e == 2) begin
             if (fam == 2) m_st[fam] = 4;
             else begin m_st[fam] = 7; m_tgt[fam] = 1; end
           end
        4: if (e == 1) begin m_st[fam] = 7; m_tgt[fam] = 0; end
           else if (e == 3) m_st[fam] = 6;
        default: ;
      endcase
    end
  endtask

  task automatic step(logic [8:0] m);
    int prev [3];
    @(negedge clk);
    ev = m;
    @(posedge clk);
    #1;
    for (int f = 0; f < 3; f++) begin
      prev[f] = m_st[f];
      model_step(f, m);
      chk(int'(code[f]) == exp_code(f, m_st[f]), tag_of(prev[f]), code[f], exp_code(f, m_st[f]));
      chk({rq_rd[f], rq_iv[f], rq_wb[f]} == {m_st[f] == 5, m_st[f] == 6, m_st[f] == 7},
          "R12", {rq_rd[f], rq_iv[f], rq_wb[f]}, {m_st[f] == 5, m_st[f] == 6, m_st[f] == 7});
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int f = 0; f < 3; f++) begin m_st[f] = 0; m_tgt[f] = 0; end
    repeat (3) @(posedge clk);
    #1;
    for (int f = 0; f < 3; f++) // R1 reset state
      chk(code[f] == 3'b000 && !rq_rd[f] && !rq_iv[f] && !rq_wb[f], "R1", code[f], 0);
    @(negedge clk) rst_n = 1'b1;

    // walk through no-copy fill, exclusive, owned, wait, write-back
    step(9'h020);
    chk(code[2] == 3'b101 && rq_rd[2], "R2", code[2], 5);
    step(9'h080);
    chk(code[2] == 3'b010 && code[0] == 3'b001, "R2", code[2], 2);
    step(9'h002);
    chk(code[2] == 3'b011 && !rq_iv[2], "R3", code[2], 3);
    step(9'h004);
    chk(code[2] == 3'b100 && !rq_wb[2], "R6", code[2], 4);
    chk(code[1] == 3'b110 && rq_wb[1], "R6", code[1], 6);
    step(9'h004);
    chk(code[2] == 3'b100 && !rq_wb[2], "R7", code[2], 4);
    step(9'h002);
    chk(code[2] == 3'b111 && rq_iv[2], "R4", code[2], 7);
    step(9'h008);
    chk(code[2] == 3'b111, "R8", code[2], 7);
    step(9'h080);
    chk(code[2] == 3'b011, "R4", code[2], 3);
    step(9'h00E);
    chk(code[2] == 3'b110 && rq_wb[2], "R9", code[2], 6);
    step(9'h100);
    chk(code[2] == 3'b000 && code[1] == 3'b001, "R5", code[2], 0);

    // shared path on a fresh line
    step(9'h008); step(9'h100); step(9'h008);
    step(9'h010);
    step(9'h080);
    chk(code[2] == 3'b001, "R2", code[2], 1);
    step(9'h004);
    step(9'h001);
    chk(code[2] == 3'b001, "R11", code[2], 1);
    step(9'h008);
    chk(code[2] == 3'b000, "R11", code[2], 0);

    // pseudo-random sweep of strobe combinations
    for (int i = 0; i < 6000; i++) begin
      logic [8:0] m;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m = 9'd1 << (lfsr[3:0] % 9);
      if (lfsr[8]) m = m | (9'd1 << (lfsr[12:9] % 9));
      if (lfsr[15:14] == 2'b00) m = '0;
      step(m);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule